// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-attached watchdog. A free-running tick enable is first divided by a fixed factor of 32. The result then advances a counter whose terminal value is a power of two. The exponent of that power comes from a configuration input that is captured during reset. Software keeps the system alive by writing a 16-bit service key into the upper half-word of the control register. If the counter reaches its terminal value first, the block raises a one-cycle reset request and latches a sticky cause flag, which software can inspect after the system restarts.

The control word holds an enable bit and a window bit, which software can change. It also reports the captured postscale exponent and clock-select value, which are read-only. The enable and window bits can be changed in three ways: through a direct write with byte enables, through a set alias, or through a clear alias. Software clears the cause flag through its own clear alias. For one cycle after the enable bit drops, the block ignores every bus access.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control word (offset 0x00) reads back as follows: enable bit 15 = 0, postscale field bits 12:8 = captured `cfg_postscale`, clock-select bits 7:6 = captured `cfg_clksel`, window bit 0 = captured `cfg_win`, all other bits 0. The cause register (offset 0x10) reads 0, and `rst_req` is 0.
- R2: With the enable bit set and `wd_tick` high on every cycle, `rst_req` goes high for exactly one cycle once 32·2^N ticks have been counted after the enabling write, where N is the postscale field. The counter then restarts, so the next request follows a further 32·2^N ticks.
- R3: A write to offset 0x00 with byte enables exactly 4'b1100 and `bus_wdata[31:16]` = 0x5743 restarts the count from zero. Any other value, and the same value written with any other byte enables, leaves the count undisturbed.
- R4: While the enable bit is 0 the count is held at zero and no reset request occurs. While `wd_tick` is 0 the count does not advance.
- R5: A write to the set alias (0x08) sets, and a write to the clear alias (0x04) clears, each enable/window bit whose mask bit is 1 and whose byte lane is enabled.
- R6: A direct write to 0x00 updates bit 0 only when byte enable 0 is set, and bit 15 only when byte enable 1 is set. Bits 12:8 and 7:6 never change through the bus.
- R7: A reset request sets bit 4 of the cause register in the same cycle. Bits 2 and 3 read 0. The flag stays set until a 1 is written to bit 4 of the cause clear alias (0x14) with byte enable 0 set. A direct write to 0x10 has no effect.
- R8: In the cycle right after the enable bit goes from 1 to 0, any write is ignored, and a read in that cycle returns 0.
- R9: The window bit has no effect on timing: with it set, requests occur exactly as in R2.
- R10: `bus_rdata` carries the addressed register in the cycle after `bus_rd` is sampled, and reads 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| wd_tick | input | 1 | Watchdog tick enable, one count per high cycle |
| cfg_postscale | input | 5 | Postscale exponent N, captured in reset |
| cfg_clksel | input | 2 | Clock-select code, captured in reset, read-only |
| cfg_win | input | 1 | Initial value of the window bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 4 | Byte-lane enables of a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
Every bus operation takes one clock edge. A write's effect is visible from the next cycle, and read data is sampled half a cycle after the edge that captures the read. The reset request is registered on the same edge that counts the final tick, so a request 32·2^N ticks after an enabling or servicing write is sampled exactly 32·2^N edges after that write's edge. The bench counts edges explicitly from the write to that sample. The bench also counts requests across each window, which shows that a service key removed an earlier deadline. The blackout read is placed on the edge directly after the disabling write.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int ADDR_W   = 5;
  localparam int POST_W   = 5;
  localparam int CSEL_W   = 2;
  localparam int PRE_LOG2 = 5;

  localparam logic [ADDR_W-1:0] A_CTL       = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTL_CLR   = 5'h04;
  localparam logic [ADDR_W-1:0] A_CTL_SET   = 5'h08;
  localparam logic [ADDR_W-1:0] A_CAUSE     = 5'h10;
  localparam logic [ADDR_W-1:0] A_CAUSE_CLR = 5'h14;

  localparam int B_EN       = 15;
  localparam int B_WIN      = 0;
  localparam int B_CAUSE    = 4;
  localparam int POST_LSB   = 8;
  localparam int CSEL_LSB   = 6;

  localparam logic [15:0]      SVC_KEY  = 16'h5743;
  localparam logic [LANES-1:0] KEY_LANES = 4'b1100;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [POST_W-1:0] cfg_post,
  input  logic [CSEL_W-1:0] cfg_csel,
  input  logic              cfg_win,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cause_set,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [POST_W-1:0] post_q,
  output logic              en_q,
  output logic              key_hit,
  output logic              cause_q,
  output logic              clr_hit,
  output logic              blk_q
);
  logic [CSEL_W-1:0] csel_q;
  logic              win_q;
  logic              wr_ok, rd_ok;
  logic [DATA_W-1:0] wmask;
  logic              en_d, win_d;
  logic [DATA_W-1:0] ctl_word, cause_word, rd_d;
  logic              lint_unused;

  assign wr_ok = bus_wr & ~blk_q;
  assign rd_ok = bus_rd & ~blk_q;
  assign wmask = bus_wdata & lane_mask(bus_be);
  assign lint_unused = ^wmask;

  always_comb begin
    en_d  = en_q;
    win_d = win_q;
    if (wr_ok) begin
      unique case (bus_addr)
        A_CTL: begin
          if (bus_be[B_EN/8])  en_d  = bus_wdata[B_EN];
          if (bus_be[B_WIN/8]) win_d = bus_wdata[B_WIN];
        end
        A_CTL_SET: begin
          en_d  = en_q  | wmask[B_EN];
          win_d = win_q | wmask[B_WIN];
        end
        A_CTL_CLR: begin
          en_d  = en_q  & ~wmask[B_EN];
          win_d = win_q & ~wmask[B_WIN];
        end
        default: ;
      endcase
    end
  end

  assign key_hit = wr_ok && (bus_addr == A_CTL) && (bus_be == KEY_LANES)
                   && (bus_wdata[DATA_W-1 -: 16] == SVC_KEY);
  assign clr_hit = wr_ok && (bus_addr == A_CAUSE_CLR) && wmask[B_CAUSE];

  always_comb begin
    ctl_word = '0;
    ctl_word[B_EN]                 = en_q;
    ctl_word[B_WIN]                = win_q;
    ctl_word[POST_LSB +: POST_W]   = post_q;
    ctl_word[CSEL_LSB +: CSEL_W]   = csel_q;
    cause_word = '0;
    cause_word[B_CAUSE] = cause_q;
    rd_d = '0;
    if (rd_ok) begin
      if (bus_addr == A_CTL)        rd_d = ctl_word;
      else if (bus_addr == A_CAUSE) rd_d = cause_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_q    <= cfg_post;
      csel_q    <= cfg_csel;
      win_q     <= cfg_win;
      en_q      <= 1'b0;
      cause_q   <= 1'b0;
      blk_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      en_q      <= en_d;
      win_q     <= win_d;
      cause_q   <= cause_set | (cause_q & ~clr_hit);
      blk_q     <= en_q & ~en_d;
      bus_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int PRE_LOG2 = 5,
  parameter int POST_W   = 5,
  localparam int CNT_W   = 2 ** POST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              restart,
  input  logic [POST_W-1:0] post,
  output logic              hit_q,
  output logic [PRE_LOG2-1:0] pre_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [PRE_LOG2-1:0] pre_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    terminal;
  logic                pre_wrap, hit;

  assign terminal = {{(CNT_W-1){1'b0}}, 1'b1} << post;
  assign pre_wrap = tick && (pre_q == {PRE_LOG2{1'b1}});
  assign hit      = run && !restart && pre_wrap && ((cnt_q + CNT_W'(1)) == terminal);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || hit) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= pre_q + PRE_LOG2'(1);
      if (pre_wrap) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit;
  end

  assign pre_o = pre_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_tick,
  input  logic [4:0]        cfg_postscale,
  input  logic [1:0]        cfg_clksel,
  input  logic              cfg_win,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [4:0]        bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam int CNT_W = 2 ** POST_W;

  logic [POST_W-1:0]   post_w;
  logic                en_w, key_w, cause_w, clr_w, blk_w;
  logic [PRE_LOG2-1:0] pre_w;
  logic [CNT_W-1:0]    cnt_w;

  kwdt_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_post  (cfg_postscale),
    .cfg_csel  (cfg_clksel),
    .cfg_win   (cfg_win),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .cause_set (rst_req_d),
    .bus_rdata (bus_rdata),
    .post_q    (post_w),
    .en_q      (en_w),
    .key_hit   (key_w),
    .cause_q   (cause_w),
    .clr_hit   (clr_w),
    .blk_q     (blk_w)
  );

  logic rst_req_d;

  kwdt_count #(.PRE_LOG2(PRE_LOG2), .POST_W(POST_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .run     (en_w),
    .tick    (wd_tick),
    .restart (key_w),
    .post    (post_w),
    .hit_q   (rst_req),
    .pre_o   (pre_w),
    .cnt_o   (cnt_w)
  );

  assign rst_req_d = u_count.hit;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int PRE_LOG2 = 5,
  parameter int CNT_W    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                rst_req,
  input logic                en_q,
  input logic                cause_q,
  input logic                clr_hit,
  input logic                key_hit,
  input logic                blk_q,
  input logic [PRE_LOG2-1:0] pre,
  input logic [CNT_W-1:0]    cnt
);
  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7
  cause_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> cause_q);

  // R7
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cause_q) && !$past(clr_hit)) |-> cause_q);

  // R4
  off_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !rst_req);

  // R4
  off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> (cnt == '0 && pre == '0));

  // R3
  key_restart_chk: assert property (@(posedge clk) disable iff (rst)
    key_hit |=> (cnt == '0 && pre == '0));

  // R8
  blackout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    blk_q |=> $stable(en_q));
endmodule

bind keyed_wdt keyed_wdt_chk #(.PRE_LOG2(kwdt_pkg::PRE_LOG2), .CNT_W(2 ** kwdt_pkg::POST_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rst_req (rst_req),
  .en_q    (en_w),
  .cause_q (cause_w),
  .clr_hit (clr_w),
  .key_hit (key_w),
  .blk_q   (blk_w),
  .pre     (pre_w),
  .cnt     (cnt_w)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wd_tick = 1'b0;
  logic [4:0]  cfg_postscale = '0;
  logic [1:0]  cfg_clksel = '0;
  logic        cfg_win = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int n_chk = 0, n_bad = 0, pulses = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .rst(rst), .wd_tick(wd_tick),
    .cfg_postscale(cfg_postscale), .cfg_clksel(cfg_clksel), .cfg_win(cfg_win),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(negedge clk) if (!rst && rst_req) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cycles, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  typedef struct packed {
    logic        rd;
    logic [4:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00000380, 4'd1},  // R1
    '{1'b0, 5'h08, 4'hF, 32'h00008000, 32'h0,        4'd5},  // R5 set enable
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00008380, 4'd5},
    '{1'b0, 5'h00, 4'h1, 32'h00008001, 32'h0,        4'd6},  // R6 lane 0 only
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00008381, 4'd6},
    '{1'b0, 5'h04, 4'h1, 32'h00000001, 32'h0,        4'd5},  // R5 clear window
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00008380, 4'd5},
    '{1'b0, 5'h00, 4'hF, 32'h00009FC1, 32'h0,        4'd6},  // R6 read-only fields
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00008381, 4'd6},
    '{1'b0, 5'h04, 4'h1, 32'h00008000, 32'h0,        4'd5},  // R5 lane off
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00008381, 4'd5},
    '{1'b0, 5'h00, 4'h2, 32'h00000000, 32'h0,        4'd6},  // R6 lane 1 clears enable
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00000000, 4'd8},  // R8 blackout read
    '{1'b1, 5'h00, 4'h0, 32'h0,        32'h00000381, 4'd6},
    '{1'b0, 5'h10, 4'hF, 32'h00000010, 32'h0,        4'd7},  // R7 direct write ignored
    '{1'b1, 5'h10, 4'h0, 32'h0,        32'h00000000, 4'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_reset(input logic [4:0] post, input logic [1:0] cs, input logic w);
    cfg_postscale = post; cfg_clksel = cs; cfg_win = w; wd_tick = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    int p0;
    @(negedge clk);

    // table walk, tick held low
    do_reset(5'd3, 2'd2, 1'b0);
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        rd(TBL[i].addr, d);
        check($sformatf("R%0d vector %0d", TBL[i].req, i), d, TBL[i].exp);
      end else begin
        wr(TBL[i].addr, TBL[i].be, TBL[i].data);
      end
    end

    // R1 reset state
    do_reset(5'd0, 2'd1, 1'b0);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rd(5'h00, d); check("R1 control", d, 32'h00000040);
    rd(5'h10, d); check("R1 cause", d, 32'h0);
    idle(1);      check("R10 idle rdata", bus_rdata, 32'h0);

    // R2 timing, N = 0
    wd_tick = 1'b1;
    wr(5'h08, 4'hF, 32'h00008000);
    idle(31); check("R2 before terminal", {31'b0, rst_req}, 32'h0);
    idle(1);  check("R2 at terminal", {31'b0, rst_req}, 32'h1);
    idle(1);  check("R2 single cycle", {31'b0, rst_req}, 32'h0);
    idle(30); check("R2 second period early", {31'b0, rst_req}, 32'h0);
    idle(1);  check("R2 second period", {31'b0, rst_req}, 32'h1);
    wr(5'h04, 4'hF, 32'h00008000);
    idle(1);
    wr(5'h10, 4'hF, 32'h00000000);
    rd(5'h10, d); check("R7 sticky after direct write", d, 32'h00000010);
    wr(5'h14, 4'h1, 32'h00000010);
    rd(5'h10, d); check("R7 cleared", d, 32'h0);

    // R4 disabled with ticks
    p0 = pulses;
    idle(200);
    check("R4 no request when disabled", pulses - p0, 0);

    // R3 service key, N = 1
    do_reset(5'd1, 2'd0, 1'b0);
    wd_tick = 1'b1;
    p0 = pulses;
    wr(5'h08, 4'hF, 32'h00008000);
    idle(39);
    wr(5'h00, 4'hC, 32'h57430000);
    idle(63);
    check("R3 key removed deadline", pulses - p0, 0);
    check("R3 before new terminal", {31'b0, rst_req}, 32'h0);
    idle(1);  check("R3 new terminal", {31'b0, rst_req}, 32'h1);
    idle(19);
    wr(5'h00, 4'hC, 32'h57440000);
    wr(5'h00, 4'hF, 32'h57438000);
    wr(5'h00, 4'h4, 32'h57430000);
    idle(41); check("R3 bad keys before terminal", {31'b0, rst_req}, 32'h0);
    idle(1);  check("R3 bad keys ignored", {31'b0, rst_req}, 32'h1);

    // R4 tick low, N = 0
    do_reset(5'd0, 2'd0, 1'b0);
    p0 = pulses;
    wr(5'h08, 4'hF, 32'h00008000);
    idle(100);
    check("R4 no advance without tick", pulses - p0, 0);
    wd_tick = 1'b1;
    idle(31); check("R4 count from zero", {31'b0, rst_req}, 32'h0);
    idle(1);  check("R4 first terminal", {31'b0, rst_req}, 32'h1);

    // R9 window bit set
    do_reset(5'd0, 2'd0, 1'b1);
    rd(5'h00, d); check("R9 window bit", d, 32'h00000001);
    wd_tick = 1'b1;
    wr(5'h08, 4'hF, 32'h00008000);
    idle(31); check("R9 before terminal", {31'b0, rst_req}, 32'h0);
    idle(1);  check("R9 terminal", {31'b0, rst_req}, 32'h1);

    // R8 blackout write
    wd_tick = 1'b0;
    wr(5'h04, 4'hF, 32'h00008000);
    wr(5'h08, 4'hF, 32'h00008000);
    rd(5'h00, d); check("R8 write ignored", d, 32'h00000001);
    wr(5'h08, 4'hF, 32'h00008000);
    rd(5'h00, d); check("R8 later write works", d, 32'h00008001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule